// File: doc/BRIEF.md
# Ready-Counter Bus Slave

This block is an on-chip bus slave that holds a small register file behind a fixed, parameterised access latency. The master starts an access with a strobe that lasts one clock cycle: a read strobe with an address, or a write strobe with an address and write data. The slave captures the command on that edge, so the master may change or drop address and data immediately afterwards.

Completion is not reported with a single acknowledge. The slave drives a 2-bit count of the cycles left, saturated at 3. The master can see that the end is near and plan its own pipeline. A count of 0 means the last read result is on the data port or the last write has landed. The read result stays on the port until another read completes, so the master may collect it whenever it likes.

The slave publishes two constant pipeline levels, one for reads and one for writes. It accepts a new command before the current one has finished whenever the count is below the level that applies. At level 3 it parks the early command in a second command register until the running access ends. A command that arrives when it is not allowed is dropped and raises a sticky error flag.

Top module: `rcnt_slave`

## Requirements
- R1: A command is taken from the one cycle in which its strobe is high. Address and write data driven in later cycles have no effect on that access.
- R2: For an access accepted when the slave is free, with latency L, the count in the k-th cycle after the command cycle is min(L+1-k, 3) for k = 1..L+1, and it ends at 0.
- R3: While no read completes, the read data port holds its value and an idle slave holds the count at 0. A completed write does not change the read data port.
- R4: A read result sits in the low DATA_W bits of the 32-bit data port, with the upper bits zero. It appears in the first cycle in which that read's count is 0. A write stores only the low DATA_W bits of the write data.
- R5: With latency 0, the count is 0 in the cycle right after the command, and a read result is already present in that cycle.
- R6: The read-level and write-level outputs are 2-bit constants equal to the RD_LEVEL and WR_LEVEL parameters.
- R7: A read command is accepted only if the count is below RD_LEVEL, and a write command only if it is below WR_LEVEL. A count of 3 never admits a command.
- R8: A command accepted at count 2 under level 3 is held. The older access completes on its own schedule, and the held access then counts down from min(L,3) in the same cycle in which the older result appears.
- R9: A command accepted at count 1 starts at once. In the next cycle the older access has completed and the count shows min(L,3) for the new one.
- R10: A command that is not admitted, or read and write strobes raised together, is ignored: no register changes and the running access keeps its timing. It sets the error flag, which stays set until reset.
- R11: After reset the count is 0, the read data is 0, the error flag is clear and every register reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_i | input | 1 | One-cycle read strobe |
| wr_i | input | 1 | One-cycle write strobe |
| addr_i | input | ADDR_W | Word address, valid with a strobe |
| wdata_i | input | BUS_W | Write data, valid with the write strobe |
| rdata_o | output | BUS_W | Held read result, zero-padded above DATA_W |
| rdy_cnt_o | output | 2 | Saturating count of cycles left; 0 means done |
| rd_level_o | output | 2 | Constant read pipeline level |
| wr_level_o | output | 2 | Constant write pipeline level |
| err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bench sweeps every register with writes and reads and checks the count in every cycle against min(L+1-k,3). An off-by-one in the countdown, or a result that shows up a cycle early or late, is caught in the cycle where it happens. It overlaps reads at count 2 and writes at count 1 against the two different levels. A slave that lost the parked command, or that let the new access overwrite the older result before its cycle, would show the wrong data or count. Commands are also offered at counts 2 and 3 where they are forbidden. A design that obeyed such a command, or disturbed the running access, leaves a changed register or a shifted countdown. A zero-latency build is driven back-to-back to show that it never reports a nonzero count and never delays data.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;

  // Clamp a remaining-cycle value onto the 2-bit ready count.
  function automatic logic [1:0] sat_cnt(input int unsigned v);
    if (v >= 3) return 2'd3;
    return 2'(v);
  endfunction

endpackage

// File: rtl/rcs_rst_sync.sv
module rcs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_n_o = s1_q;

endmodule

// File: rtl/rcs_timer.sv
module rcs_timer #(
  parameter int LATENCY = 3,
  parameter int REM_W   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  output logic [1:0] cnt_o,
  output logic       last_o
);
  import rcs_pkg::*;

  logic [REM_W-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (load_i)            rem_d = REM_W'(LATENCY);
    else if (rem_q != '0)  rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign cnt_o  = sat_cnt(int'(rem_q));
  assign last_o = (rem_q == REM_W'(1));

endmodule

// File: rtl/rcs_hold_q.sv
module rcs_hold_q #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  rcs_pkg::op_e      op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              valid_o,
  output rcs_pkg::op_e      op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  import rcs_pkg::*;

  logic              vld_q, vld_d;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;

  always_comb begin
    vld_d = vld_q;
    if (pop_i)  vld_d = 1'b0;
    if (push_i) vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      op_q   <= OP_RD;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      vld_q <= vld_d;
      if (push_i) begin
        op_q   <= op_i;
        addr_q <= addr_i;
        wd_q   <= wdata_i;
      end
    end
  end

  assign valid_o = vld_q;
  assign op_o    = op_q;
  assign addr_o  = addr_q;
  assign wdata_o = wd_q;

endmodule

// File: rtl/rcs_regfile.sv
module rcs_regfile #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin_i,
  input  rcs_pkg::op_e      op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BUS_W-1:0]  rdata_o
);
  import rcs_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DEPTH-1:0]             we;
  logic [DATA_W-1:0]            rd_q;
  logic                         rd_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign we[g] = fin_i && (op_i == OP_WR) && (addr_i == ADDR_W'(g));
  end

  assign rd_en = fin_i && (op_i == OP_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we[i]) mem_q[i] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem_q[addr_i];
  end

  assign rdata_o = BUS_W'(rd_q);

endmodule

// File: rtl/rcnt_slave.sv
module rcnt_slave #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 16,
  parameter int BUS_W    = 32,
  parameter int LATENCY  = 3,
  parameter int RD_LEVEL = 3,
  parameter int WR_LEVEL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [1:0]        rdy_cnt_o,
  output logic [1:0]        rd_level_o,
  output logic [1:0]        wr_level_o,
  output logic              err_o
);
  import rcs_pkg::*;

  localparam int REM_W    = (LATENCY > 3) ? $clog2(LATENCY + 1) : 2;
  localparam bit ZERO_LAT = (LATENCY == 0);

  logic              srst_n;
  logic [1:0]        cnt;
  logic              last;
  logic              one_cmd, any_cmd, acc, direct, push, pop;
  op_e               new_op;
  logic [1:0]        lvl;
  logic [DATA_W-1:0] new_wd;

  logic              q_valid;
  op_e               q_op;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wd;

  op_e               act_op, act_op_d;
  logic [ADDR_W-1:0] act_addr, act_addr_d;
  logic [DATA_W-1:0] act_wd, act_wd_d;
  logic              act_en;

  logic              fin;
  op_e               fin_op;
  logic [ADDR_W-1:0] fin_addr;
  logic [DATA_W-1:0] fin_wd;

  logic              err_q, err_d;

  rcs_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(srst_n));

  if (DATA_W < BUS_W) begin : g_drop_hi
    logic unused_hi;
    assign unused_hi = ^wdata_i[BUS_W-1:DATA_W];
  end

  // Command decode and admission against the pipeline level.
  assign new_wd  = wdata_i[DATA_W-1:0];
  assign one_cmd = rd_i ^ wr_i;
  assign any_cmd = rd_i | wr_i;
  assign new_op  = wr_i ? OP_WR : OP_RD;
  assign lvl     = (new_op == OP_WR) ? 2'(WR_LEVEL) : 2'(RD_LEVEL);
  assign acc     = one_cmd && !q_valid && (cnt < lvl);
  assign direct  = acc && (cnt < 2'd2);
  assign push    = acc && (cnt == 2'd2);
  assign pop     = q_valid;

  rcs_hold_q #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(srst_n), .push_i(push), .pop_i(pop),
    .op_i(new_op), .addr_i(addr_i), .wdata_i(new_wd),
    .valid_o(q_valid), .op_o(q_op), .addr_o(q_addr), .wdata_o(q_wd)
  );

  rcs_timer #(.LATENCY(LATENCY), .REM_W(REM_W)) u_timer (
    .clk(clk), .rst_n(srst_n), .load_i(act_en),
    .cnt_o(cnt), .last_o(last)
  );

  // Active command register: loaded from the port or from the hold slot.
  always_comb begin
    act_en     = direct | pop;
    act_op_d   = act_op;
    act_addr_d = act_addr;
    act_wd_d   = act_wd;
    if (direct) begin
      act_op_d   = new_op;
      act_addr_d = addr_i;
      act_wd_d   = new_wd;
    end else if (pop) begin
      act_op_d   = q_op;
      act_addr_d = q_addr;
      act_wd_d   = q_wd;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      act_op   <= OP_RD;
      act_addr <= '0;
      act_wd   <= '0;
    end else if (act_en) begin
      act_op   <= act_op_d;
      act_addr <= act_addr_d;
      act_wd   <= act_wd_d;
    end
  end

  // Completion: zero latency finishes on the command edge itself.
  if (ZERO_LAT) begin : g_fin_now
    assign fin      = direct;
    assign fin_op   = new_op;
    assign fin_addr = addr_i;
    assign fin_wd   = new_wd;
  end else begin : g_fin_late
    assign fin      = last;
    assign fin_op   = act_op;
    assign fin_addr = act_addr;
    assign fin_wd   = act_wd;
  end

  rcs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_rf (
    .clk(clk), .rst_n(srst_n), .fin_i(fin), .op_i(fin_op),
    .addr_i(fin_addr), .wdata_i(fin_wd), .rdata_o(rdata_o)
  );

  always_comb err_d = err_q | (any_cmd & ~acc);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign rdy_cnt_o  = cnt;
  assign err_o      = err_q;
  assign rd_level_o = 2'(RD_LEVEL);
  assign wr_level_o = 2'(WR_LEVEL);

endmodule

// File: rtl/rcnt_slave_chk.sv
module rcnt_slave_chk #(
  parameter int DATA_W  = 16,
  parameter int BUS_W   = 32,
  parameter int LATENCY = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       rdy_cnt,
  input logic [BUS_W-1:0] rdata,
  input logic             err,
  input logic             direct,
  input logic             q_valid,
  input logic             fin,
  input rcs_pkg::op_e     fin_op
);
  import rcs_pkg::*;

  // R2: the count only climbs when an access has just been started
  p_cnt_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt > $past(rdy_cnt)) |-> $past(direct || q_valid));

  // R2: a count of 2 always steps down to 1
  p_cnt_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt == 2'd2) |=> (rdy_cnt == 2'd1));

  // R3: read data moves only when a read completes
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin && fin_op == OP_RD) |=> $stable(rdata));

  // R10: error flag is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8: a parked command exists only while the older access is in its last cycle
  p_hold_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> (rdy_cnt == 2'd1));

  if (DATA_W < BUS_W) begin : g_pad
    // R4: upper data bits are zero
    p_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[BUS_W-1:DATA_W] == '0);
  end

  if (LATENCY == 0) begin : g_zero
    // R5: zero latency never reports a wait
    p_zero_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_cnt == 2'd0);
  end

endmodule

bind rcnt_slave rcnt_slave_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(srst_n), .rdy_cnt(rdy_cnt_o), .rdata(rdata_o), .err(err_o),
  .direct(direct), .q_valid(q_valid), .fin(fin), .fin_op(fin_op)
);

// File: tb/rcnt_slave_tb.sv
module rcnt_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ML = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        m_rd = 0, m_wr = 0;
  logic [1:0]  m_addr = 0;
  logic [31:0] m_wd = 0;
  logic [31:0] m_rdata;
  logic [1:0]  m_cnt, m_rl, m_wl;
  logic        m_err;

  logic        z_rd = 0, z_wr = 0;
  logic [1:0]  z_addr = 0;
  logic [31:0] z_wd = 0;
  logic [31:0] z_rdata;
  logic [1:0]  z_cnt, z_rl, z_wl;
  logic        z_err;

  rcnt_slave #(.ADDR_W(2), .DATA_W(16), .BUS_W(32), .LATENCY(ML),
               .RD_LEVEL(3), .WR_LEVEL(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_i(m_rd), .wr_i(m_wr), .addr_i(m_addr),
    .wdata_i(m_wd), .rdata_o(m_rdata), .rdy_cnt_o(m_cnt),
    .rd_level_o(m_rl), .wr_level_o(m_wl), .err_o(m_err));

  rcnt_slave #(.ADDR_W(2), .DATA_W(16), .BUS_W(32), .LATENCY(0),
               .RD_LEVEL(1), .WR_LEVEL(1)) u_dut_z (
    .clk(clk), .rst_n(rst_n), .rd_i(z_rd), .wr_i(z_wr), .addr_i(z_addr),
    .wdata_i(z_wd), .rdata_o(z_rdata), .rdy_cnt_o(z_cnt),
    .rd_level_o(z_rl), .wr_level_o(z_wl), .err_o(z_err));

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] ref_m [4];
  logic [15:0] ref_z [4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_cnt(input int r);
    return (r >= 3) ? 2'd3 : 2'(r);
  endfunction

  // Called at a negedge; returns at the negedge after the command edge.
  task automatic m_issue(input bit r, input bit w, input logic [1:0] a, input logic [31:0] d);
    m_rd = r; m_wr = w; m_addr = a; m_wd = d;
    @(negedge clk);
    m_rd = 0; m_wr = 0; m_addr = ~a; m_wd = ~d;   // R1: later values must not matter
  endtask

  task automatic m_write(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] held;
    held = m_rdata;
    m_issue(0, 1, a, d);
    for (int k = 1; k <= ML + 1; k++) begin
      chk("R2 write countdown", 32'(m_cnt), 32'(exp_cnt(ML + 1 - k)));
      if (k < ML + 1) @(negedge clk);
    end
    chk("R3 write leaves read data", m_rdata, held);
    ref_m[a] = d[15:0];
  endtask

  task automatic m_read(input logic [1:0] a);
    logic [31:0] held;
    held = m_rdata;
    m_issue(1, 0, a, 32'h0);
    for (int k = 1; k <= ML + 1; k++) begin
      chk("R2 read countdown", 32'(m_cnt), 32'(exp_cnt(ML + 1 - k)));
      if (k <= ML) chk("R3 data held before completion", m_rdata, held);
      else         chk("R4 R1 read result padded", m_rdata, {16'h0, ref_m[a]});
      if (k < ML + 1) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) begin ref_m[i] = '0; ref_z[i] = '0; end
  endtask

  initial begin
    repeat (CLK_PERIOD * 4000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R11 reset state, R6 levels
    chk("R11 count after reset", 32'(m_cnt), 0);
    chk("R11 data after reset", m_rdata, 0);
    chk("R11 error after reset", 32'(m_err), 0);
    chk("R6 read level", 32'(m_rl), 3);
    chk("R6 write level", 32'(m_wl), 2);
    chk("R6 zero-lat read level", 32'(z_rl), 1);
    chk("R6 zero-lat write level", 32'(z_wl), 1);

    // R2 R4 sweep: all addresses, several patterns with dirty upper bits
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < 4; a++)
        m_write(2'(a), 32'hF00D_0000 ^ (32'(p) << 28) ^ (32'h1357 * (a + 1) + 32'(p * 77)));
      for (int a = 3; a >= 0; a--) m_read(2'(a));
    end

    // R3: idle hold
    repeat (3) begin
      @(negedge clk);
      chk("R3 idle count", 32'(m_cnt), 0);
      chk("R3 idle data", m_rdata, {16'h0, ref_m[0]});
    end

    // R8: read at count 2 under level 3
    m_write(2'd1, 32'h0000_1111);
    m_write(2'd2, 32'h0000_2222);
    m_read(2'd0);
    m_issue(1, 0, 2'd1, 0);                       // after E0: count 3
    @(negedge clk);                               // after E1: count 2
    chk("R8 count before overlap", 32'(m_cnt), 2);
    m_issue(1, 0, 2'd2, 0);                       // after E2
    chk("R8 older still running", 32'(m_cnt), 1);
    chk("R8 older data not yet", m_rdata, {16'h0, ref_m[0]});
    @(negedge clk);                               // after E3
    chk("R8 new countdown starts", 32'(m_cnt), 3);
    chk("R8 older result appears", m_rdata, 32'h0000_1111);
    @(negedge clk); chk("R8 count 2", 32'(m_cnt), 2);
    @(negedge clk); chk("R8 count 1", 32'(m_cnt), 1);
    chk("R8 data held", m_rdata, 32'h0000_1111);
    @(negedge clk); chk("R8 count 0", 32'(m_cnt), 0);
    chk("R8 held command result", m_rdata, 32'h0000_2222);
    chk("R7 no error for legal overlap", 32'(m_err), 0);

    // R9: write at count 1 under level 2
    m_issue(0, 1, 2'd1, 32'hABCD_4444);
    @(negedge clk);
    chk("R9 count 2", 32'(m_cnt), 2);
    @(negedge clk);
    chk("R9 count 1", 32'(m_cnt), 1);
    m_issue(0, 1, 2'd2, 32'h9876_5555);
    chk("R9 new count after overlap", 32'(m_cnt), 3);
    ref_m[1] = 16'h4444;
    @(negedge clk); @(negedge clk);
    chk("R9 count 1 again", 32'(m_cnt), 1);
    @(negedge clk);
    chk("R9 second write done", 32'(m_cnt), 0);
    ref_m[2] = 16'h5555;
    chk("R7 no error for legal write overlap", 32'(m_err), 0);
    m_read(2'd1);
    m_read(2'd2);

    // R10 R7: write at count 2 with write level 2 is refused
    m_write(2'd3, 32'h0000_3333);
    m_read(2'd0);
    m_issue(1, 0, 2'd1, 0);
    @(negedge clk);
    chk("R7 count 2 before refused write", 32'(m_cnt), 2);
    m_issue(0, 1, 2'd3, 32'h0000_DEAD);
    chk("R10 running access timing kept", 32'(m_cnt), 1);
    chk("R10 error raised", 32'(m_err), 1);
    @(negedge clk);
    chk("R10 running access completes", 32'(m_cnt), 0);
    chk("R10 running result", m_rdata, {16'h0, ref_m[1]});
    m_read(2'd3);                                 // R10: register 3 unchanged

    // R7 R10: read at count 3 is refused
    m_issue(1, 0, 2'd0, 0);
    chk("R7 count 3", 32'(m_cnt), 3);
    m_issue(1, 0, 2'd2, 0);
    chk("R7 count 3 forbids command", 32'(m_cnt), 2);
    @(negedge clk); chk("R7 count 1", 32'(m_cnt), 1);
    @(negedge clk); chk("R7 count 0", 32'(m_cnt), 0);
    chk("R7 only first read served", m_rdata, {16'h0, ref_m[0]});
    repeat (2) @(negedge clk);
    chk("R7 no late second result", m_rdata, {16'h0, ref_m[0]});
    chk("R10 error sticky", 32'(m_err), 1);

    // R11: reset clears error and registers
    do_reset();
    chk("R11 error cleared", 32'(m_err), 0);
    chk("R11 data cleared", m_rdata, 0);
    m_read(2'd3);

    // R5: zero-latency slave, back-to-back writes then reads
    for (int a = 0; a < 4; a++) begin
      z_wr = 1; z_addr = 2'(a); z_wd = 32'hC0DE_0000 | (32'h0101 * (a + 3));
      @(negedge clk);
      ref_z[a] = z_wd[15:0];
      chk("R5 zero-lat write count", 32'(z_cnt), 0);
    end
    z_wr = 0;
    for (int a = 3; a >= 0; a--) begin
      z_rd = 1; z_addr = 2'(a);
      @(negedge clk);
      chk("R5 zero-lat read count", 32'(z_cnt), 0);
      chk("R5 R4 zero-lat data next cycle", z_rdata, {16'h0, ref_z[a]});
    end
    z_rd = 0;
    chk("R5 back-to-back legal", 32'(z_err), 0);

    // R10: both strobes together
    z_rd = 1; z_wr = 1; z_addr = 2'd0; z_wd = 32'h0000_BAD0;
    @(negedge clk);
    z_rd = 0; z_wr = 0;
    chk("R10 dual strobe error", 32'(z_err), 1);
    chk("R10 dual strobe no read", z_rdata, {16'h0, ref_z[0]});
    z_rd = 1; z_addr = 2'd0;
    @(negedge clk);
    z_rd = 0;
    chk("R10 dual strobe no write", z_rdata, {16'h0, ref_z[0]});

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule